// File: doc/BRIEF.md
# CAN Receive Mailbox Acceptance Filter

This block decides whether a received CAN frame is accepted by one receive mailbox. It compares the frame's 29-bit identifier, its IDE (extended format) bit and its RTR (remote request) bit against the values stored in the mailbox's filter fields. An acceptance mask gates every compare. The upper two mask bits do not gate identifier bits. Instead they gate the RTR and IDE compares. An enhanced-compare enable decides whether those two mask bits are honoured at all.

The block holds two 32-bit mask registers. The global mask serves every mailbox. The legacy mask serves only mailbox 14, and only while per-mailbox individual masking is off. Both registers reset to all ones. They accept writes only while the controller is in freeze mode. The match flag is computed combinationally from the current frame, mailbox and mask values. Arbitration among matching mailboxes and message storage are handled outside this block.

Top module: `can_acf_top`

## Requirements
- R1: A mask bit of 0 makes the matching filter bit "don't care": identifier bit i (0..28) is ignored when mask bit i is 0. With the enhanced compare enabled and a mask of all zeros, every frame matches.
- R2: A mask bit of 1 makes the matching identifier bit take part in the compare. When the mailbox IDE bit is 1 (extended), all 29 identifier bits are compared under mask bits 28:0.
- R3: When the mailbox IDE bit is 0 (standard), only identifier bits 28:18 are compared. Bits 17:0 never affect the match.
- R4: With the enhanced compare enabled, mask bit 31 gates the RTR compare and mask bit 30 gates the IDE compare. A differing bit blocks the match only when its mask bit is 1.
- R5: With the enhanced compare disabled, the RTR bits are never compared. The IDE bits are always compared, whatever mask bits 31:30 hold.
- R6: For mailbox index 14 with individual masking off, the legacy mask is used. For any other index, or with individual masking on, the global mask is used.
- R7: After reset, both mask registers hold all ones.
- R8: A write with the write select at 0 targets the global mask, and with the write select at 1 it targets the legacy mask. The write takes effect on the next clock edge only if freeze is high. Writes outside freeze mode leave both masks unchanged.
- R9: The match output follows the frame and mailbox inputs combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze_i | input | 1 | Controller is in freeze mode; mask writes allowed |
| indiv_mask_i | input | 1 | Individual per-mailbox masking active; legacy mask disabled |
| enh_cmp_i | input | 1 | Enhanced compare enable for RTR/IDE |
| wr_en_i | input | 1 | Mask register write strobe |
| wr_sel_i | input | 1 | Write target: 0 global mask, 1 legacy mask |
| wr_data_i | input | 32 | Mask write data |
| frm_id_i | input | 29 | Incoming frame identifier (standard ID in bits 28:18) |
| frm_ide_i | input | 1 | Incoming frame IDE bit |
| frm_rtr_i | input | 1 | Incoming frame RTR bit |
| mb_id_i | input | 29 | Mailbox filter identifier |
| mb_ide_i | input | 1 | Mailbox filter IDE bit |
| mb_rtr_i | input | 1 | Mailbox filter RTR bit |
| mb_idx_i | input | 4 | Index of the mailbox being tested |
| match_o | output | 1 | Frame is accepted by the mailbox |

## Verification
Frame and mailbox pairs are built to differ in exactly one place: one low identifier bit, a standard-ID bit, the RTR bit or the IDE bit. Each pair is tried under masks that clear exactly that position, so a wrong bit-to-mask mapping shows up as a flipped match. The same pairs are run with the enhanced compare on and off, which separates the masked RTR/IDE path from the fixed one. Mailbox indices 14 and 13 are tried with individual masking on and off, and writes are issued in and out of freeze, to show which mask is used and whether a register could change.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;
  localparam int unsigned ID_W    = 29;
  localparam int unsigned MASK_W  = 32;
  localparam int unsigned STD_LO  = 18;
  localparam int unsigned RTR_BIT = 31;
  localparam int unsigned IDE_BIT = 30;
  localparam int unsigned NUM_MASK_REGS = 2;

  typedef enum logic {
    MSEL_GLOBAL = 1'b0,
    MSEL_LEGACY = 1'b1
  } mask_sel_e;

  typedef struct packed {
    logic            rtr;
    logic            ide;
    logic [ID_W-1:0] id;
  } filt_fields_t;
endpackage

// File: rtl/can_acf_mask_regs.sv
module can_acf_mask_regs
  import can_acf_pkg::*;
#(
  parameter int unsigned W = MASK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze_i,
  input  logic         wr_en_i,
  input  logic         wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] glb_mask_o,
  output logic [W-1:0] lgc_mask_o
);
  logic [W-1:0] mask_q [NUM_MASK_REGS];
  logic [W-1:0] mask_d [NUM_MASK_REGS];
  logic         mask_en [NUM_MASK_REGS];

  for (genvar g = 0; g < NUM_MASK_REGS; g++) begin : g_reg
    always_comb begin
      mask_en[g] = freeze_i && wr_en_i && (wr_sel_i == g[0]);
      mask_d[g]  = mask_en[g] ? wr_data_i : mask_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[g] <= '1;
      end else if (mask_en[g]) begin
        mask_q[g] <= mask_d[g];
      end
    end
  end

  assign glb_mask_o = mask_q[MSEL_GLOBAL];
  assign lgc_mask_o = mask_q[MSEL_LEGACY];

  AST_NO_WRITE_OUTSIDE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze_i |=> ($stable(glb_mask_o) && $stable(lgc_mask_o))); // R8
  AST_GLOBAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && wr_en_i && !wr_sel_i) |=> (glb_mask_o == $past(wr_data_i))); // R8
  AST_LEGACY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && wr_en_i && wr_sel_i) |=> (lgc_mask_o == $past(wr_data_i))); // R8
endmodule

// File: rtl/can_acf_mask_sel.sv
module can_acf_mask_sel
  import can_acf_pkg::*;
#(
  parameter int unsigned W      = MASK_W,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned LEG_MB = 14
) (
  input  logic [IDX_W-1:0] mb_idx_i,
  input  logic             indiv_mask_i,
  input  logic [W-1:0]     glb_mask_i,
  input  logic [W-1:0]     lgc_mask_i,
  output logic [W-1:0]     eff_mask_o
);
  localparam logic [IDX_W-1:0] LEG_IDX = IDX_W'(LEG_MB);

  mask_sel_e sel;

  always_comb begin
    sel = ((mb_idx_i == LEG_IDX) && !indiv_mask_i) ? MSEL_LEGACY : MSEL_GLOBAL;
    eff_mask_o = (sel == MSEL_LEGACY) ? lgc_mask_i : glb_mask_i;
  end
endmodule

// File: rtl/can_acf_compare.sv
module can_acf_compare
  import can_acf_pkg::*;
(
  input  filt_fields_t      frm_i,
  input  filt_fields_t      mb_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              enh_cmp_i,
  output logic              id_hit_o,
  output logic              ide_hit_o,
  output logic              rtr_hit_o,
  output logic              match_o
);
  localparam logic [ID_W-1:0] STD_SPAN = {{(ID_W-STD_LO){1'b1}}, {STD_LO{1'b0}}};

  logic [ID_W-1:0] care;
  logic [ID_W-1:0] diff;

  always_comb begin
    care      = mask_i[ID_W-1:0] & (mb_i.ide ? {ID_W{1'b1}} : STD_SPAN);
    diff      = frm_i.id ^ mb_i.id;
    id_hit_o  = ((diff & care) == '0);
    if (enh_cmp_i) begin
      ide_hit_o = !mask_i[IDE_BIT] || (frm_i.ide == mb_i.ide);
      rtr_hit_o = !mask_i[RTR_BIT] || (frm_i.rtr == mb_i.rtr);
    end else begin
      ide_hit_o = (frm_i.ide == mb_i.ide);
      rtr_hit_o = 1'b1;
    end
    match_o = id_hit_o && ide_hit_o && rtr_hit_o;
  end
endmodule

// File: rtl/can_acf_top.sv
module can_acf_top
  import can_acf_pkg::*;
#(
  parameter int unsigned NUM_MB = 16,
  parameter int unsigned LEG_MB = 14,
  localparam int unsigned IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_i,
  input  logic              indiv_mask_i,
  input  logic              enh_cmp_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [MASK_W-1:0] wr_data_i,
  input  logic [ID_W-1:0]   frm_id_i,
  input  logic              frm_ide_i,
  input  logic              frm_rtr_i,
  input  logic [ID_W-1:0]   mb_id_i,
  input  logic              mb_ide_i,
  input  logic              mb_rtr_i,
  input  logic [IDX_W-1:0]  mb_idx_i,
  output logic              match_o
);
  logic [MASK_W-1:0] glb_mask;
  logic [MASK_W-1:0] lgc_mask;
  logic [MASK_W-1:0] eff_mask;
  filt_fields_t      frm;
  filt_fields_t      mb;
  logic              id_hit;
  logic              ide_hit;
  logic              rtr_hit;

  assign frm = '{rtr: frm_rtr_i, ide: frm_ide_i, id: frm_id_i};
  assign mb  = '{rtr: mb_rtr_i,  ide: mb_ide_i,  id: mb_id_i};

  can_acf_mask_regs #(.W(MASK_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .freeze_i   (freeze_i),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .glb_mask_o (glb_mask),
    .lgc_mask_o (lgc_mask)
  );

  can_acf_mask_sel #(.W(MASK_W), .IDX_W(IDX_W), .LEG_MB(LEG_MB)) u_sel (
    .mb_idx_i     (mb_idx_i),
    .indiv_mask_i (indiv_mask_i),
    .glb_mask_i   (glb_mask),
    .lgc_mask_i   (lgc_mask),
    .eff_mask_o   (eff_mask)
  );

  can_acf_compare u_cmp (
    .frm_i     (frm),
    .mb_i      (mb),
    .mask_i    (eff_mask),
    .enh_cmp_i (enh_cmp_i),
    .id_hit_o  (id_hit),
    .ide_hit_o (ide_hit),
    .rtr_hit_o (rtr_hit),
    .match_o   (match_o)
  );

  AST_ZERO_MASK_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_cmp_i && eff_mask == '0) |-> match_o); // R1
  AST_IDE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (!enh_cmp_i && frm_ide_i != mb_ide_i) |-> !match_o); // R5
  AST_RTR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!enh_cmp_i && frm_ide_i == mb_ide_i && frm_id_i == mb_id_i) |-> match_o); // R5
  AST_STD_LOW_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mb_ide_i && frm_ide_i == mb_ide_i && frm_rtr_i == mb_rtr_i
     && frm_id_i[ID_W-1:STD_LO] == mb_id_i[ID_W-1:STD_LO]) |-> match_o); // R3
  AST_GLOBAL_FOR_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (indiv_mask_i || mb_idx_i != IDX_W'(LEG_MB)) |-> (eff_mask == glb_mask)); // R6
endmodule

// File: tb/can_acf_top_bench.sv
module can_acf_top_bench;
  typedef struct packed {
    logic [31:0] mask;
    logic        enh;
    logic [28:0] fid;
    logic        fide;
    logic        frtr;
    logic [28:0] mid;
    logic        mide;
    logic        mrtr;
    logic        exp;
    logic [7:0]  req;
  } vec_t;

  localparam logic [28:0] IDA = 29'h1234567;
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'hFFFFFFFF, 1'b0, IDA, 1'b1, 1'b1, IDA, 1'b1, 1'b0, 1'b1, 8'd5},            // R5 rtr ignored
    '{32'hFFFFFFFF, 1'b0, IDA, 1'b0, 1'b0, IDA, 1'b1, 1'b0, 1'b0, 8'd5},            // R5 ide compared
    '{32'hFFFFFFFF, 1'b1, IDA, 1'b1, 1'b1, IDA, 1'b1, 1'b0, 1'b0, 8'd4},            // R4 rtr checked
    '{32'h7FFFFFFF, 1'b1, IDA, 1'b1, 1'b1, IDA, 1'b1, 1'b0, 1'b1, 8'd4},            // R4 rtr masked
    '{32'hFFFFFFFF, 1'b1, IDA, 1'b0, 1'b0, IDA, 1'b1, 1'b0, 1'b0, 8'd4},            // R4 ide checked
    '{32'hBFFFFFFF, 1'b1, IDA, 1'b0, 1'b0, IDA, 1'b1, 1'b0, 1'b1, 8'd4},            // R4 ide masked
    '{32'hFFFFFFFF, 1'b1, IDA ^ 29'h1, 1'b1, 1'b0, IDA, 1'b1, 1'b0, 1'b0, 8'd2},    // R2 ext bit0
    '{32'hFFFFFFFE, 1'b1, IDA ^ 29'h1, 1'b1, 1'b0, IDA, 1'b1, 1'b0, 1'b1, 8'd1},    // R1 bit0 dont care
    '{32'hFFFFFFFF, 1'b1, IDA ^ 29'h1, 1'b0, 1'b0, IDA, 1'b0, 1'b0, 1'b1, 8'd3},    // R3 std low ignored
    '{32'hFFFFFFFF, 1'b1, IDA ^ 29'h40000, 1'b0, 1'b0, IDA, 1'b0, 1'b0, 1'b0, 8'd3},// R3 std bit18
    '{32'hFFFBFFFF, 1'b1, IDA ^ 29'h40000, 1'b0, 1'b0, IDA, 1'b0, 1'b0, 1'b1, 8'd1},// R1 bit18 dont care
    '{32'h00000000, 1'b0, IDA, 1'b0, 1'b0, IDA, 1'b1, 1'b0, 1'b0, 8'd5},            // R5 ide despite zero mask
    '{32'h00000000, 1'b1, ~IDA, 1'b0, 1'b1, IDA, 1'b1, 1'b0, 1'b1, 8'd1}            // R1 all dont care
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        freeze_i, indiv_mask_i, enh_cmp_i, wr_en_i, wr_sel_i;
  logic [31:0] wr_data_i;
  logic [28:0] frm_id_i, mb_id_i;
  logic        frm_ide_i, frm_rtr_i, mb_ide_i, mb_rtr_i;
  logic [3:0]  mb_idx_i;
  logic        match_o;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  can_acf_top u_can_acf_top (
    .clk(clk), .rst_n(rst_n), .freeze_i(freeze_i), .indiv_mask_i(indiv_mask_i),
    .enh_cmp_i(enh_cmp_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .frm_id_i(frm_id_i), .frm_ide_i(frm_ide_i),
    .frm_rtr_i(frm_rtr_i), .mb_id_i(mb_id_i), .mb_ide_i(mb_ide_i),
    .mb_rtr_i(mb_rtr_i), .mb_idx_i(mb_idx_i), .match_o(match_o)
  );

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (match_o !== exp) begin
      n_fail++;
      $display("FAIL %s: match_o=%b expected %b", req, match_o, exp);
    end
  endtask

  task automatic wr_mask(input logic frz, input logic sel, input logic [31:0] d);
    @(negedge clk);
    freeze_i = frz; wr_sel_i = sel; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; freeze_i = 1'b0;
  endtask

  task automatic set_frame(input logic [28:0] fid, input logic fide, input logic frtr,
                           input logic [28:0] mid, input logic mide, input logic mrtr);
    frm_id_i = fid; frm_ide_i = fide; frm_rtr_i = frtr;
    mb_id_i = mid; mb_ide_i = mide; mb_rtr_i = mrtr;
    #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; freeze_i = 1'b0; indiv_mask_i = 1'b0; enh_cmp_i = 1'b1;
    wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0; mb_idx_i = 4'd3;
    set_frame(IDA, 1'b1, 1'b0, IDA, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: reset leaves every bit checked in both masks
    set_frame(IDA, 1'b1, 1'b1, IDA, 1'b1, 1'b0);
    check(1'b0, "R7 global rtr bit set");
    set_frame(IDA ^ 29'h1, 1'b1, 1'b0, IDA, 1'b1, 1'b0);
    check(1'b0, "R7 global id bit0 set");
    mb_idx_i = 4'd14;
    set_frame(IDA ^ 29'h1, 1'b1, 1'b0, IDA, 1'b1, 1'b0);
    check(1'b0, "R7 legacy id bit0 set");
    mb_idx_i = 4'd3;

    // R8: writes outside freeze are ignored
    wr_mask(1'b0, 1'b0, 32'h0);
    wr_mask(1'b0, 1'b1, 32'h0);
    set_frame(IDA ^ 29'h1, 1'b1, 1'b0, IDA, 1'b1, 1'b0);
    check(1'b0, "R8 global unchanged outside freeze");
    mb_idx_i = 4'd14;
    #1;
    check(1'b0, "R8 legacy unchanged outside freeze");
    mb_idx_i = 4'd3;

    // Vector table against the global mask
    for (int i = 0; i < NV; i++) begin
      wr_mask(1'b1, 1'b0, VECS[i].mask);
      enh_cmp_i = VECS[i].enh;
      set_frame(VECS[i].fid, VECS[i].fide, VECS[i].frtr,
                VECS[i].mid, VECS[i].mide, VECS[i].mrtr);
      check(VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R6: legacy mask for mailbox 14 only, and only without individual masking
    enh_cmp_i = 1'b1;
    wr_mask(1'b1, 1'b0, 32'hFFFFFFFF);
    wr_mask(1'b1, 1'b1, 32'hFFFFFFFE);
    set_frame(IDA ^ 29'h1, 1'b1, 1'b0, IDA, 1'b1, 1'b0);
    mb_idx_i = 4'd14; indiv_mask_i = 1'b0; #1;
    check(1'b1, "R6 mailbox 14 uses legacy mask");
    indiv_mask_i = 1'b1; #1;
    check(1'b0, "R6 individual masking disables legacy mask");
    indiv_mask_i = 1'b0; mb_idx_i = 4'd13; #1;
    check(1'b0, "R6 mailbox 13 uses global mask");
    mb_idx_i = 4'd15; #1;
    check(1'b0, "R6 mailbox 15 uses global mask");

    // R8: write in freeze visible only after the edge
    @(negedge clk);
    freeze_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = 32'hFFFFFFFE; wr_en_i = 1'b1;
    #1;
    check(1'b0, "R8 no effect before clock edge");
    @(negedge clk);
    wr_en_i = 1'b0; freeze_i = 1'b0;
    check(1'b1, "R8 global write after edge");

    // R9: match follows inputs without a clock edge
    @(negedge clk);
    set_frame(IDA ^ 29'h2, 1'b1, 1'b0, IDA, 1'b1, 1'b0);
    check(1'b0, "R9 combinational drop");
    set_frame(IDA, 1'b1, 1'b0, IDA, 1'b1, 1'b0);
    check(1'b1, "R9 combinational rise");

    // R7: a second reset restores all-ones masks
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mb_idx_i = 4'd14;
    set_frame(IDA ^ 29'h1, 1'b1, 1'b0, IDA, 1'b1, 1'b0);
    check(1'b0, "R7 legacy back to ones");
    mb_idx_i = 4'd3; #1;
    check(1'b0, "R7 global back to ones");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule